// File: doc/BRIEF.md
# Serial Output-Port Frame Serializer

This block turns a 32-bit output-port image into a continuous serial stream. It acts as clock master and drives three lines: a bit clock, a word-select line and a data line. Those lines feed a chain of external shift registers that serve as extra output pins. Each frame carries exactly one 32-bit word, sent most significant bit first. The word-select line keeps one level for a whole frame and flips at every frame boundary.

Port words arrive from an upstream source through a valid/ready handshake. The block takes at most one word per frame, at the frame boundary. If no word is offered at that point, it sends the previous word again. An optional split mode builds the upper half of every frame from a static register, which is updated one pin at a time. The lower half still comes from the stream. The bit clock is derived from the block clock through two programmable integer dividers. A start pulse (re)starts framing, and a stop pulse lets the frame in progress finish before the block goes idle.

Top module: `ser_port_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `bck`, `ws` and `sdo` are low, and `in_ready` is low unless `start` is high.
- R2: While running, one bit lasts M*B clock cycles, where M is the master divider and B is the bit divider, both captured when `start` is seen. Within each bit, `bck` is low for the first floor(B/2)*M cycles and high for the rest.
- R3: A frame is 32 bits. Bit 31 of the frame word goes out first and bit 0 goes out last. `sdo` holds its value for the whole of each bit.
- R4: `ws` is 0 during the first frame after a start, keeps its level for the whole of a frame, and inverts at every frame boundary.
- R5: `in_ready` is high only in a load cycle. A load cycle is the cycle in which `start` is high, or the last cycle of a frame that is followed by another frame. A word is taken when `in_valid` and `in_ready` are both high.
- R6: If `in_valid` is low in a load cycle, the next frame repeats the last word that was taken. Before any word has been taken, that word is 0.
- R7: With `split_en` high in a load cycle, frame bits 31..16 come from the static register and bits 15..0 come from the stream word. With `split_en` low, all 32 bits come from the stream word.
- R8: A pin write (`pin_we` high) with `split_en` high and `pin_idx` of 16 or more sets static-register bit `pin_idx`-16 to `pin_val`. Every other pin write is ignored. The static register resets to 0.
- R9: A master divider below 2 is used as 2, and one above 256 is used as 256. A bit divider below 2 is used as 2.
- R10: A `start` while running abandons the current frame. The next cycle begins a fresh frame at bit 31 with `ws` low, and the divider settings are re-captured.
- R11: A `stop` while running lets the current frame finish, and the block is idle from the next cycle. A `stop` while idle is ignored. If `start` and `stop` are high in the same cycle, `start` wins and no stop stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: begin (or restart) framing |
| stop | input | 1 | Pulse: halt at the end of the current frame |
| mdiv | input | MDIV_W | Master divider setting |
| bdiv | input | BDIV_W | Bit divider setting |
| split_en | input | 1 | Split mode: upper half of each frame from the static register |
| pin_we | input | 1 | Single-pin write strobe |
| pin_idx | input | log2(FRAME_W) | Pin index of the write |
| pin_val | input | 1 | Value written to the pin |
| in_valid | input | 1 | Upstream word valid |
| in_word | input | FRAME_W | Upstream port word |
| in_ready | output | 1 | Word accepted this cycle if valid |
| bck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, toggles per frame |
| sdo | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with its default widths: a 32-bit frame, a 9-bit master divider limited to 256, and an 8-bit bit divider. It drives the dividers at runtime to 2/2, 3/3, under-range 0/1 and over-range 300/2. These settings cover a short even bit period, odd divider values where `bck` is not split evenly, and both clamp limits, including a full frame at the largest master divider. A behavioural model predicts all four outputs on every cycle through streaming, repeated words, restarts, split frames with gated pin writes, and stops in each of their timings.

// File: rtl/ser_port_pkg.sv
// Package for the serial output-port serializer.
// Holds the default frame width and a clamp helper for the divider settings.
// Assumes divider settings are unsigned and no wider than 32 bits.
package ser_port_pkg;

    localparam int PKG_FRAME_W = 32;

    // Limit a divider setting to the range [lo, hi].
    function automatic int unsigned clamp_div(int unsigned v, int unsigned lo, int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/sp_clkdiv.sv
// Two-stage bit-clock divider.
// A prescaler counts m_div reference cycles; each time it wraps, the edge counter advances.
// One bit lasts m_div*b_div cycles. bit_end pulses in the last cycle of a bit.
// The bit-clock level is low for the first half (rounded down) of the edge count.
// Assumes m_div >= 2 and b_div >= 2, both held stable while en is high.
module sp_clkdiv #(
    parameter int MDIV_W = 9,
    parameter int BDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [MDIV_W-1:0] m_div,
    input  logic [BDIV_W-1:0] b_div,
    output logic              bit_end,
    output logic              bck_lvl
);
    localparam logic [MDIV_W-1:0] M_ONE = 1;
    localparam logic [BDIV_W-1:0] B_ONE = 1;

    logic [MDIV_W-1:0] pre_cnt;
    logic [BDIV_W-1:0] edge_cnt;
    logic              pre_wrap;

    assign pre_wrap = (pre_cnt == m_div - M_ONE);
    assign bit_end  = en && pre_wrap && (edge_cnt == b_div - B_ONE);
    assign bck_lvl  = (edge_cnt >= (b_div >> 1));

    // Advance the prescaler and edge counters while the serializer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_cnt  <= '0;
            edge_cnt <= '0;
        end else if (en) begin
            if (pre_wrap) begin
                pre_cnt  <= '0;
                edge_cnt <= (edge_cnt == b_div - B_ONE) ? '0 : edge_cnt + B_ONE;
            end else begin
                pre_cnt  <= pre_cnt + M_ONE;
            end
        end
    end

endmodule

// File: rtl/sp_shifter.sv
// Frame shifter.
// Loads a frame word, shifts it out MSB first one bit per bit_end, and flags the last bit.
// On each load it inverts word select; a restart load forces word select low instead.
// Assumes load can only be high on a start or on the last cycle of a frame.
module sp_shifter #(
    parameter int FRAME_W = 32,
    localparam int IDX_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               restart,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic               bit_end,
    output logic               msb,
    output logic               frame_last,
    output logic               ws_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [IDX_W-1:0]   bit_idx;

    assign msb        = shreg[FRAME_W-1];
    assign frame_last = bit_end && (bit_idx == LAST_IDX);

    // Load a new frame or shift out the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            ws_q    <= 1'b0;
        end else if (load) begin
            shreg   <= frame_word;
            bit_idx <= '0;
            ws_q    <= restart ? 1'b0 : ~ws_q;
        end else if (bit_end) begin
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

endmodule

// File: rtl/sp_static_reg.sv
// Static upper-half register used in split mode.
// A pin write updates one bit only when split mode is on and the pin index is in the upper half.
// Assumes pin indices address a FRAME_W-bit port image.
module sp_static_reg #(
    parameter int FRAME_W = 32,
    localparam int IDX_W  = $clog2(FRAME_W),
    localparam int HALF_W = FRAME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              split_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              val,
    output logic [HALF_W-1:0] stat_q
);
    logic [HALF_W-1:0] wr_mask;

    // Decode one write-enable per upper-half pin.
    for (genvar i = 0; i < HALF_W; i++) begin : g_dec
        assign wr_mask[i] = we && split_en && (idx == IDX_W'(HALF_W + i));
    end

    // Apply the decoded single-bit write.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~wr_mask) | (wr_mask & {HALF_W{val}});
    end

endmodule

// File: rtl/ser_port_tx.sv
// Serial output-port serializer, top level.
// Streams FRAME_W-bit port words as serial frames with bit clock, word select and data.
// A word is taken at each frame boundary; with no word offered, the last one is resent.
// In split mode the upper half of each frame comes from the static register.
// Assumes start and stop are single-cycle pulses; divider settings are captured on start.
module ser_port_tx import ser_port_pkg::*; #(
    parameter int FRAME_W  = PKG_FRAME_W,
    parameter int MDIV_W   = 9,
    parameter int BDIV_W   = 8,
    parameter int MDIV_MAX = 256,
    parameter int DIV_MIN  = 2,
    localparam int IDX_W   = $clog2(FRAME_W),
    localparam int HALF_W  = FRAME_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  logic [MDIV_W-1:0]  mdiv,
    input  logic [BDIV_W-1:0]  bdiv,
    input  logic               split_en,
    input  logic               pin_we,
    input  logic [IDX_W-1:0]   pin_idx,
    input  logic               pin_val,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_word,
    output logic               in_ready,
    output logic               bck,
    output logic               ws,
    output logic               sdo
);
    localparam int BDIV_MAX = (1 << BDIV_W) - 1;

    logic               run_q;
    logic               stop_pend_q;
    logic [MDIV_W-1:0]  m_q;
    logic [BDIV_W-1:0]  b_q;
    logic [FRAME_W-1:0] last_q;
    logic [HALF_W-1:0]  stat;
    logic               bit_end, bck_lvl, frame_end, msb, ws_q;
    logic               stop_req, halt, load;
    logic [FRAME_W-1:0] src_word, frame_word;

    assign stop_req   = stop_pend_q | stop;
    assign halt       = frame_end & stop_req & ~start;
    assign load       = start | (frame_end & ~stop_req);
    assign in_ready   = load;
    assign src_word   = in_valid ? in_word : last_q;
    assign frame_word = split_en ? {stat, src_word[HALF_W-1:0]} : src_word;

    assign bck = run_q & bck_lvl;
    assign ws  = run_q & ws_q;
    assign sdo = run_q & msb;

    // Run/stop control and divider capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            m_q         <= MDIV_W'(DIV_MIN);
            b_q         <= BDIV_W'(DIV_MIN);
        end else if (start) begin
            run_q       <= 1'b1;
            stop_pend_q <= 1'b0;
            m_q         <= MDIV_W'(clamp_div(32'(mdiv), DIV_MIN, MDIV_MAX));
            b_q         <= BDIV_W'(clamp_div(32'(bdiv), DIV_MIN, BDIV_MAX));
        end else if (halt) begin
            run_q       <= 1'b0;
            stop_pend_q <= 1'b0;
        end else if (run_q && stop) begin
            stop_pend_q <= 1'b1;
        end
    end

    // Remember the last accepted stream word for repeats.
    always_ff @(posedge clk) begin
        if (!rst_n)                last_q <= '0;
        else if (load && in_valid) last_q <= in_word;
    end

    sp_clkdiv #(.MDIV_W(MDIV_W), .BDIV_W(BDIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(start), .en(run_q),
        .m_div(m_q), .b_div(b_q), .bit_end(bit_end), .bck_lvl(bck_lvl)
    );

    sp_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .restart(start),
        .frame_word(frame_word), .bit_end(bit_end),
        .msb(msb), .frame_last(frame_end), .ws_q(ws_q)
    );

    sp_static_reg #(.FRAME_W(FRAME_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .we(pin_we), .split_en(split_en),
        .idx(pin_idx), .val(pin_val), .stat_q(stat)
    );

endmodule

// File: rtl/sp_checker.sv
// Assertion checker for the serializer, bound to the top module.
// Observes the outputs together with the divider and shifter handshake signals.
module sp_checker #(
    parameter int MDIV_W = 9,
    parameter int BDIV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              run,
    input logic              in_ready,
    input logic              ws,
    input logic              sdo,
    input logic              bck,
    input logic              bit_end,
    input logic              frame_end,
    input logic [MDIV_W-1:0] m_q,
    input logic [BDIV_W-1:0] b_q
);
    // R1: idle means quiet lines
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!bck && !ws && !sdo));

    // R5: ready only on a start or at a frame end
    a_r5_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (start || frame_end));

    // R3: data holds between bit boundaries
    a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(bit_end) && !$past(start)) |-> $stable(sdo));

    // R4: word select holds within a frame
    a_r4_ws_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(in_ready)) |-> $stable(ws));

    // R2: each bit starts with the bit clock low
    a_r2_bck_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ($past(bit_end) || $past(start))) |-> !bck);

    // R11: running only ends at a frame end
    a_r11_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(frame_end));

    // R9: captured dividers are within range
    a_r9_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(m_q) >= 2 && int'(m_q) <= 256 && int'(b_q) >= 2));

endmodule

bind ser_port_tx sp_checker #(.MDIV_W(MDIV_W), .BDIV_W(BDIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run_q), .in_ready(in_ready),
    .ws(ws), .sdo(sdo), .bck(bck), .bit_end(bit_end), .frame_end(frame_end),
    .m_q(m_q), .b_q(b_q)
);

// File: tb/ser_port_tx_bench.sv
`timescale 1ns/100ps
// Bench for the serializer: a behavioural reference model predicts every output each cycle.
module ser_port_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stop = 1'b0;
    logic [8:0]  mdiv = 9'd2;
    logic [7:0]  bdiv = 8'd2;
    logic        split_en = 1'b0, pin_we = 1'b0, pin_val = 1'b0;
    logic [4:0]  pin_idx = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = 32'h9A3C_5E71;
    logic        in_ready, bck, ws, sdo;

    int    checks = 0, errors = 0;
    string phase = "R1 reset";
    bit    cmp_en = 0, feed = 0, acc_seen = 0, done = 0;

    // reference model state
    bit          mrun, spend, wsv;
    int          t, per, mm, bb;
    logic [31:0] fw, lastw, w;
    logic [15:0] stat;
    bit          endf, halt, load;

    always #2.5 clk = ~clk;

    ser_port_tx u_ser_port_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mdiv(mdiv), .bdiv(bdiv),
        .split_en(split_en), .pin_we(pin_we), .pin_idx(pin_idx), .pin_val(pin_val),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .bck(bck), .ws(ws), .sdo(sdo)
    );

    function automatic int clampv(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) got %b expected %b at %0t", req, phase, act, exp, $time);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin : model
        if (!rst_n) begin
            mrun = 0; spend = 0; wsv = 0; t = 0; mm = 2; bb = 2; per = 4;
            fw = '0; lastw = '0; stat = '0;
        end else begin
            endf = mrun && (t == 32 * per - 1);
            halt = endf && (spend || stop) && !start;
            load = start || (endf && !spend && !stop);
            if (load) begin
                w = in_valid ? in_word : lastw;
                if (in_valid) lastw = in_word;
                fw = split_en ? {stat, w[15:0]} : w;
            end
            if (start) begin
                mm = clampv(int'(mdiv), 2, 256);
                bb = clampv(int'(bdiv), 2, 255);
                per = mm * bb; t = 0; wsv = 0; mrun = 1; spend = 0;
            end else if (mrun) begin
                if (halt) begin
                    mrun = 0; spend = 0;
                end else if (endf) begin
                    t = 0; wsv = !wsv;
                end else begin
                    t++;
                    if (stop) spend = 1;
                end
            end
            if (pin_we && split_en && pin_idx >= 5'd16) stat[int'(pin_idx) - 16] = pin_val;
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin : compare
        int  k, e;
        logic eb, es, ew, er;
        if (cmp_en) begin
            k  = t / per;
            e  = (t % per) / mm;
            eb = mrun && (e >= bb / 2);
            es = mrun && fw[31 - k];
            ew = mrun && wsv;
            er = start || (mrun && (t == 32 * per - 1) && !spend && !stop);
            chk1("R2", bck, eb);
            chk1("R3", sdo, es);
            chk1("R4", ws, ew);
            chk1("R5", in_ready, er);
        end
        acc_seen = in_ready && in_valid;
    end

    task automatic tick();
        @(posedge clk);
        #1;
        if (acc_seen && feed) in_word = in_word * 32'h0019_660D + 32'h3C6E_F35F;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : stim
        tick();
        cmp_en = 1;
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk1("R1", bck, 1'b0);
        chk1("R1", ws, 1'b0);
        chk1("R1", sdo, 1'b0);
        chk1("R1", in_ready, 1'b0);
        tick();

        phase = "R2 R3 R4 R5 R7 streaming";
        mdiv = 9'd2; bdiv = 8'd2; in_valid = 1'b1; feed = 1;
        pulse_start();
        run(3 * 128 + 10);

        phase = "R6 repeat without valid";
        in_valid = 1'b0;
        run(2 * 128 + 5);
        in_valid = 1'b1;

        phase = "R10 R2 restart with odd dividers";
        mdiv = 9'd3; bdiv = 8'd3;
        pulse_start();
        run(2 * 288 + 20);

        phase = "R8 R7 split mode and pin writes";
        split_en = 1'b0; pin_we = 1'b1; pin_idx = 5'd20; pin_val = 1'b1; tick();
        split_en = 1'b1; pin_idx = 5'd5; tick();
        pin_idx = 5'd31; tick();
        pin_idx = 5'd16; tick();
        pin_idx = 5'd24; tick();
        pin_we = 1'b0;
        run(2 * 288 + 20);
        pin_we = 1'b1; pin_idx = 5'd31; pin_val = 1'b0; tick();
        pin_we = 1'b0;
        run(300);

        phase = "R11 stop finishes frame";
        split_en = 1'b0;
        stop = 1'b1; tick(); stop = 1'b0;
        run(320);
        phase = "R11 stop while idle ignored";
        stop = 1'b1; tick(); stop = 1'b0;
        run(5);
        mdiv = 9'd2; bdiv = 8'd2;
        pulse_start();
        run(200);
        phase = "R11 start beats stop";
        start = 1'b1; stop = 1'b1; tick(); start = 1'b0; stop = 1'b0;
        run(200);

        phase = "R9 clamp low";
        mdiv = 9'd0; bdiv = 8'd1;
        pulse_start();
        run(140);
        phase = "R9 clamp high";
        mdiv = 9'd300; bdiv = 8'd2;
        pulse_start();
        stop = 1'b1; tick(); stop = 1'b0;
        run(32 * 512 + 50);

        done = 1;
        summary();
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

endmodule